// File: doc/BRIEF.md
# Dual Counter Clock Source Selector

This block decides, cycle by cycle, when each of two downstream 16-bit timer/counters may advance. It produces one single-cycle count-enable strobe per counter. Each counter has its own 3-bit source choice. The counter can be stopped, or it can advance on a tick from a shared programmable divider of the system clock. It can also advance once for each qualifying edge on an external event pin, on the divider tick while that pin sits at a chosen level (pulse accumulation), or once for each tick of a slow reference input.

The external pin and the slow reference both pass through a synchronizer before any edge or level decision. One polarity input gives the active edge in edge mode and the active level in accumulate mode. The edge and accumulate sources are honoured only when the surrounding timer runs in one of the two operating modes that free the pin for that use. In the other two modes they stay silent. A small byte-wide register port holds the divider value and both source fields, and software uses it to configure the block.

Top module: `tmr_clksrc_unit`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, both stored registers read back as zero and both `cnt_en` bits are low; with all-zero selects nothing counts.
- R2: A write with `reg_addr`=0 stores the divider value from `reg_wdata[4:0]`. A write with `reg_addr`=1 stores the counter 0 select from bits [2:0] and the counter 1 select from bits [6:4]. Bits outside these fields read back as 0, and `reg_rdata` shows the addressed register one clock after the address is presented.
- R3: With select 001, the counter's strobe fires exactly once every (divider+1) system clocks, so a 64-cycle window holds 64/(divider+1) strobes for any divider that divides 64.
- R4: Select 000 and the undefined selects 101, 110 and 111 produce no strobe.
- R5: With select 010, each edge of `pinb_in` of the active polarity gives exactly one strobe. The active edge is rising when `pinb_pol`=1 and falling when `pinb_pol`=0.
- R6: With select 011, the counter strobes on each divider tick while the synchronized `pinb_in` is at the active level, which is high when `pinb_pol`=1 and low when `pinb_pol`=0, and is silent otherwise.
- R7: Selects 010 and 011 produce strobes only when `tmr_mode` is 2'b00 or 2'b10; with `tmr_mode` 2'b01 or 2'b11 they produce none.
- R8: With select 100, each rising edge of `slow_in` gives exactly one strobe.
- R9: Each strobe lasts one clock, and the two counters are selected independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = divider register, 1 = select register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the addressed register |
| tmr_mode | input | 2 | Operating mode of the surrounding timer |
| pinb_pol | input | 1 | Edge / level polarity for the event pin |
| pinb_in | input | 1 | Asynchronous external event pin |
| slow_in | input | 1 | Asynchronous slow reference tick |
| cnt_en | output | 2 | Count-enable strobe, one bit per counter |

## Verification
The assertions assume that `pinb_in` and `slow_in` each stay at one level for at least two system clocks, so that the synchronizer sees every transition. They also assume that `tmr_mode` and `pinb_pol` hold steady while a source depends on them. The stimulus meets these assumptions. It changes both pins only on a four-clock grid, with slow pulses two clocks high. It changes the mode, polarity and registers only between measurement windows, and it waits for the divider and synchronizers to settle before each window starts.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF   = 3'b000,
    SRC_PRESC = 3'b001,
    SRC_EDGE  = 3'b010,
    SRC_ACCUM = 3'b011,
    SRC_SLOW  = 3'b100
  } src_sel_e;
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;

  // Wrapping on >= keeps the count bounded after the divider is lowered.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_DIV1: assert property (@(posedge clk) disable iff (rst)
    (div == '0 && $past(div) == '0 && !$past(rst)) |-> tick) else $error("div1 tick"); // R3
endmodule

// File: rtl/tcs_sync_edge.sv
module tcs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign level = sh[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("rise twice"); // R5
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall) else $error("fall twice"); // R9
endmodule

// File: rtl/tcs_src_sel.sv
module tcs_src_sel
  import tcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             mode_ok,
  input  logic             pol,
  input  logic             psc_tick,
  input  logic             pin_lvl,
  input  logic             pin_rise,
  input  logic             pin_fall,
  input  logic             slow_rise,
  output logic             en
);
  logic evt, gate, pick;

  assign evt  = pol ? pin_rise : pin_fall;
  assign gate = pol ? pin_lvl : ~pin_lvl;

  always_comb begin
    unique case (sel)
      SRC_PRESC: pick = psc_tick;
      SRC_EDGE:  pick = mode_ok & evt;
      SRC_ACCUM: pick = mode_ok & gate & psc_tick;
      SRC_SLOW:  pick = slow_rise;
      default:   pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) en <= 1'b0;
    else     en <= pick;
  end

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_OFF || sel > SRC_SLOW) |=> !en) else $error("stopped strobe"); // R4
  AST_PRESC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_PRESC) |=> (en == $past(psc_tick))) else $error("presc follow"); // R3
  AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok && (sel == SRC_EDGE || sel == SRC_ACCUM)) |=> !en) else $error("mode block"); // R7
  AST_ACCUM_GATE: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_ACCUM && !gate) |=> !en) else $error("accum gate"); // R6
  AST_SLOW_PASS: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_SLOW) |=> (en == $past(slow_rise))) else $error("slow pass"); // R8
endmodule

// File: rtl/tmr_clksrc_unit.sv
module tmr_clksrc_unit
  import tcs_pkg::*;
#(
  parameter int PSC_W       = 5,
  parameter int NUM_CNT     = 2,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [1:0]         tmr_mode,
  input  logic               pinb_pol,
  input  logic               pinb_in,
  input  logic               slow_in,
  output logic [NUM_CNT-1:0] cnt_en
);
  localparam int FLD_W = REG_W / NUM_CNT;

  logic [PSC_W-1:0] psc_q;
  logic [SEL_W-1:0] sel_q [NUM_CNT];
  logic [REG_W-1:0] sel_byte;
  logic             psc_tick, mode_ok;
  logic             pin_lvl, pin_rise, pin_fall;
  logic             slow_lvl, slow_rise, slow_fall;
  logic             unused_bits;

  assign unused_bits = ^{reg_wdata, slow_lvl, slow_fall};
  assign mode_ok     = ~tmr_mode[0];

  always_ff @(posedge clk) begin
    if (rst) psc_q <= '0;
    else if (reg_wr && !reg_addr) psc_q <= reg_wdata[PSC_W-1:0];
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_CNT; i++) sel_byte[i*FLD_W +: SEL_W] = sel_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_addr ? sel_byte : REG_W'(psc_q);
  end

  tcs_prescaler #(.W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .div(psc_q), .tick(psc_tick));

  tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .din(pinb_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall));

  tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_slow (
    .clk(clk), .rst(rst), .din(slow_in),
    .level(slow_lvl), .rise(slow_rise), .fall(slow_fall));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) sel_q[g] <= '0;
      else if (reg_wr && reg_addr) sel_q[g] <= reg_wdata[g*FLD_W +: SEL_W];
    end

    tcs_src_sel u_sel (
      .clk(clk), .rst(rst), .sel(sel_q[g]), .mode_ok(mode_ok), .pol(pinb_pol),
      .psc_tick(psc_tick), .pin_lvl(pin_lvl), .pin_rise(pin_rise),
      .pin_fall(pin_fall), .slow_rise(slow_rise), .en(cnt_en[g]));
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (psc_q == '0 && sel_byte == '0 && cnt_en == '0)) else $error("reset"); // R1
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sel_byte == '0) |=> (cnt_en == '0)) else $error("idle strobe"); // R1
endmodule

// File: tb/sim_tmr_clksrc_unit.sv
module sim_tmr_clksrc_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] tmr_mode = 2'b00;
  logic       pinb_pol = 1'b0, pinb_in = 1'b0, slow_in = 1'b0;
  logic [1:0] cnt_en;

  int n_chk = 0, n_bad = 0;
  int c0, c1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_clksrc_unit u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_mode(tmr_mode),
    .pinb_pol(pinb_pol), .pinb_in(pinb_in), .slow_in(slow_in), .cnt_en(cnt_en));

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] psc;
    logic [2:0] s0, s1;
    logic [1:0] md;
    logic       pol, lvl;
    logic [3:0] tog, slw;
    logic [7:0] e0, e1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 5'd0,  3'd1, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd64, 8'd0},  // R3 R4 div1
    '{4'd3, 5'd3,  3'd1, 3'd1, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd16, 8'd16}, // R3 div4
    '{4'd8, 5'd31, 3'd1, 3'd4, 2'd0, 1'b0, 1'b0, 4'd0, 4'd5, 8'd2,  8'd5},  // R8 R3 div32
    '{4'd5, 5'd7,  3'd2, 3'd1, 2'd0, 1'b1, 1'b0, 4'd3, 4'd0, 8'd3,  8'd8},  // R5 rising
    '{4'd5, 5'd7,  3'd2, 3'd0, 2'd2, 1'b0, 1'b0, 4'd4, 4'd0, 8'd4,  8'd0},  // R5 falling, mode 10
    '{4'd6, 5'd1,  3'd3, 3'd3, 2'd0, 1'b1, 1'b1, 4'd0, 4'd0, 8'd32, 8'd32}, // R6 high active
    '{4'd6, 5'd1,  3'd3, 3'd1, 2'd0, 1'b1, 1'b0, 4'd0, 4'd0, 8'd0,  8'd32}, // R6 gate closed
    '{4'd6, 5'd1,  3'd3, 3'd0, 2'd2, 1'b0, 1'b0, 4'd0, 4'd0, 8'd32, 8'd0},  // R6 low active
    '{4'd7, 5'd15, 3'd2, 3'd1, 2'd1, 1'b1, 1'b0, 4'd3, 4'd0, 8'd0,  8'd4},  // R7 edge blocked
    '{4'd7, 5'd1,  3'd3, 3'd0, 2'd3, 1'b1, 1'b1, 4'd0, 4'd0, 8'd0,  8'd0},  // R7 accum blocked
    '{4'd4, 5'd0,  3'd5, 3'd7, 2'd0, 1'b1, 1'b0, 4'd3, 4'd3, 8'd0,  8'd0},  // R4 undefined
    '{4'd9, 5'd0,  3'd4, 3'd2, 2'd0, 1'b1, 1'b0, 4'd2, 4'd6, 8'd6,  8'd2},  // R9 independent
    '{4'd4, 5'd15, 3'd6, 3'd1, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd0,  8'd4}   // R4 code 110
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = int'(reg_rdata);
  endtask

  // 64-cycle window: pin toggles every 4 cycles, slow pulses 2 high / 2 low
  task automatic window(input int tog, input int slw);
    c0 = 0; c1 = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      c0 += int'(cnt_en[0]);
      c1 += int'(cnt_en[1]);
      if (c % 4 == 0 && c / 4 < 2 * tog) pinb_in = ~pinb_in;
      slow_in = (c < 4 * slw) && (c % 4 < 2);
    end
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 cnt_en in reset", int'(cnt_en), 0);
    rst = 1'b0;
    rd(1'b0, v); check("R1 divider after reset", v, 0);
    rd(1'b1, v); check("R1 select after reset", v, 0);
    window(3, 3);
    check("R1 counter0 idle", c0, 0);
    check("R1 counter1 idle", c1, 0);

    // R2: field masking and readback
    wr(1'b0, 8'hFF); rd(1'b0, v); check("R2 divider mask", v, 8'h1F);
    wr(1'b1, 8'hFF); rd(1'b1, v); check("R2 select mask", v, 8'h77);
    wr(1'b1, 8'h42); rd(1'b1, v); check("R2 select fields", v, 8'h42);

    foreach (VECS[i]) begin
      tmr_mode = VECS[i].md;
      pinb_pol = VECS[i].pol;
      pinb_in  = VECS[i].lvl;
      slow_in  = 1'b0;
      wr(1'b0, {3'b0, VECS[i].psc});
      wr(1'b1, {1'b0, VECS[i].s1, 1'b0, VECS[i].s0});
      repeat (40) @(negedge clk);
      window(int'(VECS[i].tog), int'(VECS[i].slw));
      check($sformatf("R%0d vector %0d counter0", VECS[i].req, i), c0, int'(VECS[i].e0));
      check($sformatf("R%0d vector %0d counter1", VECS[i].req, i), c1, int'(VECS[i].e1));
    end

    // R1: reset mid-run clears configuration
    wr(1'b0, 8'h03); wr(1'b1, 8'h11);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); check("R1 cnt_en after reset", int'(cnt_en), 0);
    rst = 1'b0;
    rd(1'b0, v); check("R1 divider cleared", v, 0);
    rd(1'b1, v); check("R1 select cleared", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule